// File: doc/BRIEF.md
# Coin-Accumulating Water Dispenser Controller

This controller keeps the credit for a water vending machine. Three pushbutton inputs each stand for one coin: a quarter (25 cents), a dime (10 cents) and a nickel (5 cents). A fourth input, a clear, returns the credit to zero. The running credit leaves the block as an unsigned binary cent count. A vend flag goes high once the credit reaches 50 cents.

The buttons come straight from the board and run asynchronously to a fast system clock. A person holding a button down for half a second keeps it high for tens of millions of clock cycles. Each button therefore passes through a two-stage synchroniser. The state machine credits a coin on the cycle it first sees a button high. It then parks in a wait state until every coin button is low again, so a press of any length adds exactly one coin.

A coin that would take the credit past 50 clamps it at 50. Once the credit is full the machine ignores every coin until it is cleared.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A press on `quarter_btn` adds 25 cents, a press on `dime_btn` adds 10 cents, and a press on `nickel_btn` adds 5 cents to `credit`.
- R2: A button held high for any number of cycles credits exactly one coin.
- R3: After a coin is credited, no further coin is accepted until all three coin buttons have been seen low together. A second button that is still held when the first is released is not credited.
- R4: `credit` is always a multiple of 5 in the range 0 to 50 and never decreases except on clear. A coin that would exceed 50 sets it to exactly 50 (6'b110010).
- R5: `vend` is high exactly when `credit` equals 50.
- R6: While `vend` is high, coin presses leave `credit` and `vend` unchanged until clear.
- R7: `clr` is asynchronous and active high. It drives `credit` to 0 and `vend` to 0 without waiting for a clock edge, and holds them there while it is high.
- R8: When more than one coin button is high in the same sampled cycle, only one coin is credited. The nickel wins over the dime, and the dime wins over the quarter.
- R9: A button that first goes high between two clock edges changes `credit` on the third rising edge after the change; two edges after the change `credit` still holds its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Asynchronous active-high clear of the credit |
| quarter_btn | input | 1 | Raw 25-cent button, asynchronous to clk |
| dime_btn | input | 1 | Raw 10-cent button, asynchronous to clk |
| nickel_btn | input | 1 | Raw 5-cent button, asynchronous to clk |
| credit | output | 6 | Current credit in cents, unsigned binary |
| vend | output | 1 | High while the credit equals 50 cents |

## Verification
The assertions assume that `clr` is high from time zero until the first clock edges have passed. This means `$past` of the credit always refers to a cleared value. They also assume the coin buttons are stable for at least one clock period at a time, so the synchroniser sees every change. The bench changes every input only on the falling clock edge and asserts the clear at the start of every scenario. It holds each button for many cycles and leaves the buttons low for several cycles between presses. Because of this, each press reaches the state machine as a clean, multi-cycle level.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;

    // Index of each coin inside the button vector; a lower index wins.
    localparam int COIN_N     = 3;
    localparam int IDX_NICKEL = 0;
    localparam int IDX_DIME   = 1;
    localparam int IDX_QUART  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a coin
        ST_HOLD = 2'd1,   // coin credited, waiting for all buttons low
        ST_FULL = 2'd2    // credit at the limit, coins ignored
    } vend_state_e;

    typedef struct packed {
        logic       hit;    // some coin button is high
        logic [1:0] idx;    // index of the winning button
    } coin_pick_t;

    // Cent value of the coin at a given button index.
    function automatic int coin_cents(input int idx);
        case (idx)
            IDX_NICKEL: return 5;
            IDX_DIME:   return 10;
            IDX_QUART:  return 25;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            chain <= '0;
        end else begin
            chain[0] <= raw;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign synced = chain[STAGES-1];

endmodule

// File: rtl/coin_select.sv
module coin_select
    import coin_vend_pkg::*;
#(
    parameter int CENT_W = 6
) (
    input  logic [COIN_N-1:0] btn,
    output coin_pick_t        pick,
    output logic [CENT_W-1:0] value
);

    // Lowest index has priority: nickel, then dime, then quarter.
    always_comb begin
        pick = '0;
        for (int i = COIN_N - 1; i >= 0; i--) begin
            if (btn[i]) begin
                pick.hit = 1'b1;
                pick.idx = 2'(i);
            end
        end
    end

    always_comb begin
        value = '0;
        if (pick.hit) begin
            value = CENT_W'(coin_cents(int'(pick.idx)));
        end
    end

endmodule

// File: rtl/credit_fsm.sv
module credit_fsm
    import coin_vend_pkg::*;
#(
    parameter int CENT_W = 6,
    parameter int LIMIT  = 50
) (
    input  logic              clk,
    input  logic              clr,
    input  coin_pick_t        pick,
    input  logic [CENT_W-1:0] value,
    output logic [CENT_W-1:0] credit,
    output logic              vend
);

    localparam logic [CENT_W:0]   LIM_WIDE = (CENT_W + 1)'(LIMIT);
    localparam logic [CENT_W-1:0] LIM_VAL  = CENT_W'(LIMIT);

    vend_state_e       st, st_n;
    logic [CENT_W-1:0] tot, tot_n;
    logic [CENT_W:0]   raw_sum;
    logic [CENT_W-1:0] sat_sum;

    always_comb begin
        raw_sum = {1'b0, tot} + {1'b0, value};
        sat_sum = (raw_sum >= LIM_WIDE) ? LIM_VAL : raw_sum[CENT_W-1:0];
    end

    always_comb begin
        st_n  = st;
        tot_n = tot;
        case (st)
            ST_IDLE: begin
                if (pick.hit) begin
                    tot_n = sat_sum;
                    st_n  = (sat_sum == LIM_VAL) ? ST_FULL : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!pick.hit) begin
                    st_n = ST_IDLE;
                end
            end
            ST_FULL: begin
                st_n = ST_FULL;
            end
            default: begin
                st_n  = ST_IDLE;
                tot_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            st  <= ST_IDLE;
            tot <= '0;
        end else begin
            st  <= st_n;
            tot <= tot_n;
        end
    end

    assign credit = tot;
    assign vend   = (st == ST_FULL);

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
    import coin_vend_pkg::*;
#(
    parameter int CENT_W      = 6,
    parameter int LIMIT       = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              quarter_btn,
    input  logic              dime_btn,
    input  logic              nickel_btn,
    output logic [CENT_W-1:0] credit,
    output logic              vend
);

    logic [COIN_N-1:0] raw_btn;
    logic [COIN_N-1:0] sync_btn;
    coin_pick_t        pick;
    logic [CENT_W-1:0] value;

    always_comb begin
        raw_btn             = '0;
        raw_btn[IDX_NICKEL] = nickel_btn;
        raw_btn[IDX_DIME]   = dime_btn;
        raw_btn[IDX_QUART]  = quarter_btn;
    end

    btn_sync #(
        .WIDTH  (COIN_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .clr    (clr),
        .raw    (raw_btn),
        .synced (sync_btn)
    );

    coin_select #(
        .CENT_W (CENT_W)
    ) u_sel (
        .btn    (sync_btn),
        .pick   (pick),
        .value  (value)
    );

    credit_fsm #(
        .CENT_W (CENT_W),
        .LIMIT  (LIMIT)
    ) u_fsm (
        .clk    (clk),
        .clr    (clr),
        .pick   (pick),
        .value  (value),
        .credit (credit),
        .vend   (vend)
    );

endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk #(
    parameter int CENT_W = 6,
    parameter int LIMIT  = 50
) (
    input logic              clk,
    input logic              clr,
    input logic [CENT_W-1:0] credit,
    input logic              vend
);

    localparam logic [CENT_W-1:0] LIM_VAL = CENT_W'(LIMIT);

    // R4: never above the limit
    p_le_limit_r4: assert property (@(posedge clk) disable iff (clr)
        credit <= LIM_VAL);

    // R4: only whole 5-cent steps
    p_step5_r4: assert property (@(posedge clk) disable iff (clr)
        (credit % 5) == 0);

    // R4: credit never falls without a clear
    p_no_decrease_r4: assert property (@(posedge clk) disable iff (clr)
        credit >= $past(credit));

    // R5: vend flag tracks a full credit
    p_vend_full_r5: assert property (@(posedge clk) disable iff (clr)
        vend == (credit == LIM_VAL));

    // R6: once full, nothing moves until clear
    p_full_frozen_r6: assert property (@(posedge clk) disable iff (clr)
        vend |=> (vend && $stable(credit)));

    // R2: an increment is always followed by a cycle with no change
    p_single_credit_r2: assert property (@(posedge clk) disable iff (clr)
        (credit != $past(credit)) |=> $stable(credit));

    // R7: clear holds the outputs at zero
    always @(posedge clk) begin
        if (clr) begin
            p_clear_zero_r7: assert (credit == '0 && !vend);
        end
    end

endmodule

bind coin_vend_ctrl coin_vend_chk #(
    .CENT_W (CENT_W),
    .LIMIT  (LIMIT)
) u_chk (
    .clk    (clk),
    .clr    (clr),
    .credit (credit),
    .vend   (vend)
);

// File: tb/tb_coin_vend_ctrl.sv
`timescale 1ns/1ps
module tb_coin_vend_ctrl;

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       quarter_btn = 1'b0;
    logic       dime_btn = 1'b0;
    logic       nickel_btn = 1'b0;
    logic [5:0] credit;
    logic       vend;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    coin_vend_ctrl dut (
        .clk         (clk),
        .clr         (clr),
        .quarter_btn (quarter_btn),
        .dime_btn    (dime_btn),
        .nickel_btn  (nickel_btn),
        .credit      (credit),
        .vend        (vend)
    );

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // mask bit0 = nickel, bit1 = dime, bit2 = quarter
    task automatic set_btn(input logic [2:0] m);
        nickel_btn  = m[0];
        dime_btn    = m[1];
        quarter_btn = m[2];
    endtask

    task automatic press(input logic [2:0] m, input int hold);
        @(negedge clk);
        set_btn(m);
        idle(hold);
        set_btn(3'b000);
        idle(6);
    endtask

    task automatic do_clear;
        @(negedge clk);
        clr = 1'b1;
        idle(2);
        clr = 1'b0;
        idle(2);
    endtask

    function automatic int coin_of(input logic [2:0] m);
        if (m[0]) return 5;
        if (m[1]) return 10;
        if (m[2]) return 25;
        return 0;
    endfunction

    function automatic int sat(input int v);
        return (v > 50) ? 50 : v;
    endfunction

    initial begin
        idle(3);
        // R7: outputs at zero under clear
        check("R7 reset credit", int'(credit), 0);
        check("R7 reset vend", int'(vend), 0);
        clr = 1'b0;
        idle(2);

        // R9: latency through synchroniser and state register
        @(negedge clk);
        set_btn(3'b001);
        @(posedge clk); @(posedge clk); #1;
        check("R9 no change after two edges", int'(credit), 0);
        @(posedge clk); #1;
        check("R9 updated on third edge", int'(credit), 5);
        idle(3);
        set_btn(3'b000);
        idle(6);

        // R1 R4 R5: sweep every start credit and every single coin
        for (int start = 0; start < 10; start++) begin
            for (int c = 0; c < 3; c++) begin
                logic [2:0] m;
                int exp;
                m = 3'b001 << c;
                do_clear();
                for (int k = 0; k < start; k++) press(3'b001, 3);
                check("R4 start credit", int'(credit), start * 5);
                press(m, 4 + c);
                exp = sat(start * 5 + coin_of(m));
                check("R1 R4 coin added with clamp", int'(credit), exp);
                check("R5 vend flag", int'(vend), (exp == 50) ? 1 : 0);
            end
        end

        // R8: every multi-button combination credits the priority winner
        for (int m = 3; m < 8; m++) begin
            if (m == 4) continue;
            do_clear();
            press(3'(m), 5);
            check("R8 priority", int'(credit), coin_of(3'(m)));
        end

        // R2: long hold credits once
        do_clear();
        press(3'b100, 5000);
        check("R2 long hold one quarter", int'(credit), 25);
        press(3'b010, 3000);
        check("R2 long hold one dime", int'(credit), 35);

        // R3: second button still held when first released
        do_clear();
        @(negedge clk);
        set_btn(3'b001);
        idle(8);
        set_btn(3'b011);
        idle(8);
        set_btn(3'b010);
        idle(20);
        check("R3 no credit for overlapping button", int'(credit), 5);
        set_btn(3'b000);
        idle(6);
        check("R3 still one coin after release", int'(credit), 5);
        press(3'b010, 4);
        check("R3 accepts next press", int'(credit), 15);

        // R6: coins ignored once full
        do_clear();
        press(3'b100, 4);
        press(3'b100, 4);
        check("R6 full", int'(credit), 50);
        press(3'b001, 4);
        press(3'b010, 4);
        press(3'b111, 4);
        check("R6 credit frozen", int'(credit), 50);
        check("R6 vend held", int'(vend), 1);

        // R7: asynchronous clear between edges
        @(negedge clk);
        #1 clr = 1'b1;
        #1;
        check("R7 async clear credit", int'(credit), 0);
        check("R7 async clear vend", int'(vend), 0);
        idle(2);
        clr = 1'b0;
        idle(2);
        press(3'b010, 4);
        check("R7 works after clear", int'(credit), 10);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule